// File: doc/BRIEF.md
# Buffered-Duty PWM Generator

This block drives one pulse-width-modulated output from a 10-bit up-counter. A programmable prescaler sets the counter's step rate. Software sets the cycle length through a period register and the high time through a duty register. Both registers accept writes at any moment. A written duty value reaches the comparator only through a shadow latch. That latch loads only when the counter restarts from zero, so a cycle already in progress keeps its shape.

The output rises when the counter restarts and falls when the counter reaches the latched duty. That falling edge also sets a sticky interrupt flag. An enable bit gates the flag onto the interrupt line, and software clears the flag by writing a one to it. The counter value can be read but not written. The counter halts during sleep unless an analog conversion is active.

To start the block, software loads the period and the duty, selects the prescaler, and then raises the timer and PWM enables together.

Top module: `pwm_buffered_duty`

## Requirements
- R1: While `pwm_en_i` is low, one clock edge forces `pwm_o` low and `cnt_o` to zero, and the duty latch is cleared. After reset, `pwm_o`, `cnt_o`, `tmr_flag_o` and `irq_o` are all zero.
- R2: Prescaler select code s (0..7) sets the counter step to one step every 2^(s+1) clocks. Code 0 gives 1:2 and code 7 gives 1:256.
- R3: The counter counts from 0 up to the period value (register address 0). On the next step it returns to 0, and `pwm_o` rises at that moment. A full cycle lasts (period+1) steps.
- R4: `pwm_o` falls on the step at which the counter becomes equal to the latched duty. The high time is therefore duty × ratio clocks.
- R5: A write to the duty register (address 1) does not change the cycle in progress. It takes effect from the next counter restart. On the first cycle after enabling, the duty register is latched immediately.
- R6: A latched duty of zero keeps `pwm_o` low for the whole cycle and does not set the flag.
- R7: A latched duty greater than the period keeps `pwm_o` high for the whole cycle and does not set the flag.
- R8: Each compare-driven fall of `pwm_o` sets `tmr_flag_o` on the same clock edge. The flag stays set until a write to address 2 with data bit 0 equal to 1. A write with bit 0 equal to 0 leaves it set.
- R9: `irq_o` is `tmr_flag_o` gated by the interrupt-enable bit, which is data bit 0 written to address 3.
- R10: With `sleep_i` high and `conv_active_i` low, the counter holds its value. With `conv_active_i` high, the counter keeps counting during sleep.
- R11: With `tmr_en_i` low, the counter holds its value and the prescaler is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 period, 1 duty, 2 flag clear, 3 interrupt enable |
| wr_data_i | input | 10 | Write data |
| tmr_en_i | input | 1 | Timer run enable |
| pwm_en_i | input | 1 | PWM enable; when low, holds the channel in its cleared state |
| psc_sel_i | input | 3 | Prescaler select code |
| sleep_i | input | 1 | Sleep request |
| conv_active_i | input | 1 | Analog conversion in progress |
| pwm_o | output | 1 | PWM output |
| cnt_o | output | 10 | Counter value, read-only |
| tmr_flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Gated interrupt |

## Verification
The checker watches, on every cycle, the properties that hold regardless of the programmed values:
- the cleared state while the PWM is disabled;
- the counter either holding, stepping by one, or returning to zero;
- every rise of the output landing on a zero count;
- the flag being set on the same edge as any compare-driven fall;
- the interrupt never being active without the flag;
- the counter freezing during sleep without a conversion, and while the timer is disabled.

Only the bench scenarios can show the actual pulse widths and cycle lengths for given period, duty and prescaler values. They also show that a mid-cycle duty write is deferred to the next cycle, that the zero and oversized duty cases behave as stated, and that the clear write and the interrupt enable work through the write port.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned CNT_W   = 10;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PERIOD  = 2'd0,
    REG_DUTY    = 2'd1,
    REG_FLAG_CL = 2'd2,
    REG_IRQ_EN  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned PSC_W = 2 ** SEL_W;

  logic [PSC_W-1:0] div_q;
  logic [PSC_W-1:0] limit;

  // ratio 2^(sel+1), terminal count ratio-1
  always_comb begin
    limit = '0;
    for (int i = 0; i < PSC_W; i++) begin
      if (i <= int'(sel_i)) limit[i] = 1'b1;
    end
  end

  assign tick_o = run_i && (div_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (clr_i)   div_q <= '0;
    else if (tick_o)  div_q <= '0;
    else if (run_i)   div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              match_i,
  output logic [DW-1:0]     period_o,
  output logic [DW-1:0]     duty_o,
  output logic              flag_o,
  output logic              irq_o
);
  logic ie_q;
  logic flag_clr;

  assign flag_clr = wr_en_i && (wr_addr_i == REG_FLAG_CL) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o <= '0;
      duty_o   <= '0;
      ie_q     <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        REG_PERIOD: period_o <= wr_data_i;
        REG_DUTY:   duty_o   <= wr_data_i;
        REG_IRQ_EN: ie_q     <= wr_data_i[0];
        default: ;
      endcase
    end
  end

  // set wins over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_o <= 1'b0;
    else if (match_i)  flag_o <= 1'b1;
    else if (flag_clr) flag_o <= 1'b0;
  end

  assign irq_o = flag_o & ie_q;
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwm_en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_o,
  output logic             match_o
);
  logic [CNT_W-1:0] duty_lat_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             started_q;
  logic             wrap;

  assign cnt_inc = cnt_o + 1'b1;
  assign wrap    = (cnt_o == period_i);
  assign match_o = pwm_en_i && started_q && tick_i && !wrap &&
                   (cnt_inc == duty_lat_q) && pwm_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o      <= '0;
      duty_lat_q <= '0;
      pwm_o      <= 1'b0;
      started_q  <= 1'b0;
    end else if (!pwm_en_i) begin
      cnt_o      <= '0;
      duty_lat_q <= '0;
      pwm_o      <= 1'b0;
      started_q  <= 1'b0;
    end else if (!started_q) begin
      // counter sits at zero: first latch point
      started_q  <= 1'b1;
      duty_lat_q <= duty_i;
      pwm_o      <= (duty_i != '0);
    end else if (tick_i) begin
      if (wrap) begin
        cnt_o      <= '0;
        duty_lat_q <= duty_i;
        pwm_o      <= (duty_i != '0);
      end else begin
        cnt_o <= cnt_inc;
        if (cnt_inc == duty_lat_q) pwm_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_buffered_duty.sv
module pwm_buffered_duty
  import pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              tmr_en_i,
  input  logic              pwm_en_i,
  input  logic [SEL_W-1:0]  psc_sel_i,
  input  logic              sleep_i,
  input  logic              conv_active_i,
  output logic              pwm_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              tmr_flag_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] duty;
  logic             tick;
  logic             match;
  logic             run;
  logic             psc_clr;

  assign run     = tmr_en_i && pwm_en_i && (!sleep_i || conv_active_i);
  assign psc_clr = !tmr_en_i || !pwm_en_i;

  pwm_regs #(.DW(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .match_i   (match),
    .period_o  (period),
    .duty_o    (duty),
    .flag_o    (tmr_flag_o),
    .irq_o     (irq_o)
  );

  pwm_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (psc_clr),
    .run_i  (run),
    .sel_i  (psc_sel_i),
    .tick_o (tick)
  );

  pwm_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwm_en_i (pwm_en_i),
    .tick_i   (tick),
    .period_i (period),
    .duty_i   (duty),
    .cnt_o    (cnt_o),
    .pwm_o    (pwm_o),
    .match_o  (match)
  );
endmodule

// File: rtl/pwm_buffered_duty_chk.sv
module pwm_buffered_duty_chk
  import pwm_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tmr_en_i,
  input logic             pwm_en_i,
  input logic             sleep_i,
  input logic             conv_active_i,
  input logic             pwm_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             tmr_flag_o,
  input logic             irq_o
);
  // R1
  disabled_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_en_i |=> (!pwm_o && cnt_o == '0));

  // R3
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_en_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1 || cnt_o == '0));

  // R3
  rise_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_o) |-> cnt_o == '0);

  // R8
  fall_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pwm_o) && $past(pwm_en_i)) |-> tmr_flag_o);

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> tmr_flag_o);

  // R10
  sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_en_i && sleep_i && !conv_active_i) |=> $stable(cnt_o));

  // R11
  tmr_off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_en_i && !tmr_en_i) |=> $stable(cnt_o));
endmodule

bind pwm_buffered_duty pwm_buffered_duty_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tmr_en_i      (tmr_en_i),
  .pwm_en_i      (pwm_en_i),
  .sleep_i       (sleep_i),
  .conv_active_i (conv_active_i),
  .pwm_o         (pwm_o),
  .cnt_o         (cnt_o),
  .tmr_flag_o    (tmr_flag_o),
  .irq_o         (irq_o)
);

// File: tb/pwm_buffered_duty_tb.sv
module pwm_buffered_duty_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [9:0] wr_data_i = '0;
  logic       tmr_en_i = 1'b0;
  logic       pwm_en_i = 1'b0;
  logic [2:0] psc_sel_i = '0;
  logic       sleep_i = 1'b0;
  logic       conv_active_i = 1'b0;
  logic       pwm_o;
  logic [9:0] cnt_o;
  logic       tmr_flag_o;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  pwm_buffered_duty u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .tmr_en_i(tmr_en_i), .pwm_en_i(pwm_en_i),
    .psc_sel_i(psc_sel_i), .sleep_i(sleep_i), .conv_active_i(conv_active_i),
    .pwm_o(pwm_o), .cnt_o(cnt_o), .tmr_flag_o(tmr_flag_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic setup(input int p, input int d, input int sel);
    @(negedge clk_i);
    pwm_en_i = 1'b0; tmr_en_i = 1'b0;
    wr(2'd0, 10'(p));
    wr(2'd1, 10'(d));
    psc_sel_i = 3'(sel);
    pwm_en_i = 1'b1; tmr_en_i = 1'b1;
  endtask

  // waits for a rise, returns high and full-cycle lengths in clocks
  task automatic measure(output int hi, output int per);
    logic prev;
    int lo;
    prev = pwm_o;
    forever begin
      @(negedge clk_i);
      if (pwm_o && !prev) break;
      prev = pwm_o;
    end
    hi = 0; lo = 0;
    while (pwm_o) begin hi++; @(negedge clk_i); end
    while (!pwm_o) begin lo++; @(negedge clk_i); end
    per = hi + lo;
  endtask

  task automatic t_reset();
    check("R1 reset pwm", int'(pwm_o), 0);
    check("R1 reset cnt", int'(cnt_o), 0);
    check("R1 reset flag", int'(tmr_flag_o), 0);
    check("R1 reset irq", int'(irq_o), 0);
  endtask

  task automatic t_basic();
    int hi, per;
    setup(9, 4, 0);
    measure(hi, per);
    measure(hi, per);
    check("R4 high time p9 d4 1:2", hi, 8);
    check("R3 cycle p9 1:2", per, 20);
  endtask

  task automatic t_prescale();
    int hi, per;
    setup(3, 1, 2);
    measure(hi, per);
    measure(hi, per);
    check("R2 high time 1:8", hi, 8);
    check("R2 cycle 1:8", per, 32);
    setup(1, 1, 7);
    measure(hi, per);
    measure(hi, per);
    check("R2 high time 1:256", hi, 256);
    check("R2 cycle 1:256", per, 512);
  endtask

  task automatic t_buffered();
    int hi, per;
    setup(9, 2, 0);
    measure(hi, per);
    // pwm just rose: write a new duty mid-cycle
    wr_en_i = 1'b1; wr_addr_i = 2'd1; wr_data_i = 10'd6;
    hi = 0;
    while (pwm_o) begin
      hi++;
      @(negedge clk_i);
      wr_en_i = 1'b0;
    end
    check("R5 current cycle unchanged", hi, 4);
    measure(hi, per);
    check("R5 next cycle uses new duty", hi, 12);
    check("R5 cycle length kept", per, 20);
  endtask

  task automatic t_duty_zero();
    int highs = 0;
    setup(5, 0, 0);
    wr(2'd2, 10'd1);
    repeat (60) begin
      @(negedge clk_i);
      if (pwm_o) highs++;
    end
    check("R6 zero duty stays low", highs, 0);
    check("R6 zero duty no flag", int'(tmr_flag_o), 0);
  endtask

  task automatic t_duty_big();
    int lows = 0;
    setup(5, 20, 0);
    repeat (4) @(negedge clk_i);
    wr(2'd2, 10'd1);
    repeat (60) begin
      @(negedge clk_i);
      if (!pwm_o) lows++;
    end
    check("R7 oversized duty stays high", lows, 0);
    check("R7 oversized duty no flag", int'(tmr_flag_o), 0);
  endtask

  task automatic t_irq();
    logic prev;
    setup(9, 4, 0);
    wr(2'd3, 10'd0);
    wr(2'd2, 10'd1);
    prev = pwm_o;
    forever begin
      @(negedge clk_i);
      if (prev && !pwm_o) break;
      prev = pwm_o;
    end
    check("R8 flag set with fall", int'(tmr_flag_o), 1);
    check("R9 irq masked", int'(irq_o), 0);
    wr(2'd3, 10'd1);
    check("R9 irq enabled", int'(irq_o), 1);
    wr(2'd2, 10'd0);
    check("R8 write zero keeps flag", int'(tmr_flag_o), 1);
    wr(2'd2, 10'd1);
    check("R8 write one clears flag", int'(tmr_flag_o), 0);
    check("R9 irq follows clear", int'(irq_o), 0);
    wr(2'd3, 10'd0);
  endtask

  task automatic t_sleep();
    int a, b;
    setup(1000, 500, 0);
    repeat (10) @(negedge clk_i);
    sleep_i = 1'b1;
    repeat (2) @(negedge clk_i);
    a = int'(cnt_o);
    repeat (20) @(negedge clk_i);
    b = int'(cnt_o);
    check("R10 sleep halts counter", b, a);
    conv_active_i = 1'b1;
    repeat (20) @(negedge clk_i);
    check("R10 conversion keeps counting", int'(cnt_o), a + 10);
    sleep_i = 1'b0; conv_active_i = 1'b0;
  endtask

  task automatic t_tmr_off();
    int a;
    setup(1000, 500, 0);
    repeat (10) @(negedge clk_i);
    tmr_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    a = int'(cnt_o);
    repeat (20) @(negedge clk_i);
    check("R11 timer off holds counter", int'(cnt_o), a);
    // prescaler cleared: first step comes 2 clocks after re-enable
    tmr_en_i = 1'b1;
    @(negedge clk_i);
    check("R11 no step after one clock", int'(cnt_o), a);
    @(negedge clk_i);
    check("R11 step after two clocks", int'(cnt_o), a + 1);
  endtask

  task automatic t_disable();
    setup(9, 4, 0);
    repeat (7) @(negedge clk_i);
    pwm_en_i = 1'b0;
    @(negedge clk_i);
    check("R1 disable forces pwm low", int'(pwm_o), 0);
    check("R1 disable clears counter", int'(cnt_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_basic();
    t_prescale();
    t_buffered();
    t_duty_zero();
    t_duty_big();
    t_irq();
    t_sleep();
    t_tmr_off();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule